// File: doc/BRIEF.md
# Ethernet Test Frame Sequencer

This block plays out a fixed script of four Ethernet test frames on a byte-wide GMII-style transmit interface for one channel. Each frame is assembled on the fly: a preamble and start delimiter, then destination address, source address and a two-byte length/type word. A payload follows, and the frame ends with an idle gap of at least twelve byte times. The frame check sequence is not generated. After the last frame and its gap, a done flag is raised and the interface stays idle.

The four frames come in a fixed order, each aimed at a different corner of a receive path:
- a frame of minimum size;
- a frame whose length/type word holds an EtherType;
- a frame that raises the transmit-error strobe for a single byte time;
- a frame whose length word announces a short payload, zero-filled up to the minimum size.

A clock-enable input sets the byte rate. The same instance therefore serves a 1 Gbps channel (enable always high) or a 100 Mbps or 10 Mbps channel (enable pulsed once every few clocks). Sequencing starts automatically when reset is released.

Top module: `eth_tfs_top`

## Requirements
- R1: While rst_ni is low and on the first cycle after it, txd_o is 0x00, tx_en_o, tx_er_o and done_o are 0.
- R2: On a clock edge with ce_i low, no output changes and the sequence does not advance. On each edge with ce_i high, exactly one byte time elapses.
- R3: Every frame opens with seven bytes of 0x55 and then one byte of 0xD5, all with tx_en_o high.
- R4: After the delimiter come the six destination address bytes, most significant first, then the six source address bytes, then the length/type word, high byte first.
- R5: The first frame carries length word 0x002E and 46 payload bytes, so it is 60 bytes from address to end of payload. In every frame, data payload byte k equals (k + 64*f) mod 256, where f is the frame number 0..3.
- R6: The second frame carries type word TYPE_VAL (default 0x0800, never below 0x0600) and TYPE_PAY_LEN payload bytes (default 64).
- R7: The third frame carries length word 0x002E and 46 payload bytes. tx_er_o is high for exactly one byte time, at payload index ERR_POS (default 23), and is low everywhere else in the whole sequence.
- R8: The fourth frame carries length word PAD_DATA (default 10). Payload bytes 0..PAD_DATA-1 follow the R5 pattern, and bytes PAD_DATA..45 are 0x00.
- R9: Each frame is followed by IFG_LEN (default 12) byte times with tx_en_o low and txd_o 0x00.
- R10: On the first enabled edge after the fourth gap ends, done_o goes high. From then on it stays high, with tx_en_o and tx_er_o low and txd_o 0x00.
- R11: tx_er_o is never high while tx_en_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ce_i | input | 1 | Byte-time enable; one byte per enabled edge |
| txd_o | output | 8 | Transmit data byte |
| tx_en_o | output | 1 | Transmit enable, high for preamble through payload |
| tx_er_o | output | 1 | Transmit error strobe |
| done_o | output | 1 | Sequence complete, sticky until reset |

## Verification
The assertions place no constraint on ce_i: it may stay low for any number of cycles or stay high continuously. Reset may arrive at any time, including in the middle of a frame. The parameters are assumed to satisfy TYPE_VAL >= 0x0600, PAD_DATA < 46 and ERR_POS < 46. The stimulus drives ce_i from a seeded random source at several duty ratios, and adds directed stretches with ce_i always high, long runs with it held low, a sparse enable pattern typical of a slow channel, and an asynchronous reset in the middle of a frame.

// File: rtl/eth_tfs_pkg.sv
package eth_tfs_pkg;

  localparam int NUM_FRAMES = 4;
  localparam int PRE_LEN    = 7;
  localparam int HDR_LEN    = 14;
  localparam int MIN_PAY    = 46;

  localparam logic [7:0] PRE_BYTE = 8'h55;
  localparam logic [7:0] SFD_BYTE = 8'hD5;

  localparam logic [1:0] FR_MIN  = 2'd0;
  localparam logic [1:0] FR_TYPE = 2'd1;
  localparam logic [1:0] FR_ERR  = 2'd2;
  localparam logic [1:0] FR_PAD  = 2'd3;

  typedef enum logic [2:0] {
    PH_PRE, PH_SFD, PH_HDR, PH_PAY, PH_GAP, PH_DONE
  } phase_e;

  typedef struct packed {
    logic       en;
    logic       er;
    logic [7:0] data;
  } gmii_sym_t;

endpackage

// File: rtl/eth_tfs_ctrl.sv
module eth_tfs_ctrl
  import eth_tfs_pkg::*;
#(
  parameter int CNT_W        = 7,
  parameter int IFG_LEN      = 12,
  parameter int TYPE_PAY_LEN = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ce_i,
  output phase_e           phase_o,
  output logic [1:0]       frame_o,
  output logic [CNT_W-1:0] idx_o
);

  phase_e           phase_q;
  logic [1:0]       frame_q;
  logic [CNT_W-1:0] idx_q;
  logic [CNT_W-1:0] pay_len [NUM_FRAMES];
  logic [CNT_W-1:0] ph_len;
  logic             ph_last;

  for (genvar g = 0; g < NUM_FRAMES; g++) begin : g_len
    if (g == int'(FR_TYPE)) begin : g_type
      assign pay_len[g] = CNT_W'(TYPE_PAY_LEN);
    end else begin : g_min
      assign pay_len[g] = CNT_W'(MIN_PAY);
    end
  end

  always_comb begin
    unique case (phase_q)
      PH_PRE:  ph_len = CNT_W'(PRE_LEN);
      PH_SFD:  ph_len = CNT_W'(1);
      PH_HDR:  ph_len = CNT_W'(HDR_LEN);
      PH_PAY:  ph_len = pay_len[frame_q];
      PH_GAP:  ph_len = CNT_W'(IFG_LEN);
      default: ph_len = CNT_W'(1);
    endcase
  end

  assign ph_last = (idx_q == ph_len - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_PRE;
      frame_q <= FR_MIN;
      idx_q   <= '0;
    end else if (ce_i && phase_q != PH_DONE) begin
      if (!ph_last) begin
        idx_q <= idx_q + CNT_W'(1);
      end else begin
        idx_q <= '0;
        unique case (phase_q)
          PH_PRE: phase_q <= PH_SFD;
          PH_SFD: phase_q <= PH_HDR;
          PH_HDR: phase_q <= PH_PAY;
          PH_PAY: phase_q <= PH_GAP;
          PH_GAP: begin
            if (frame_q == FR_PAD) begin
              phase_q <= PH_DONE;
            end else begin
              phase_q <= PH_PRE;
              frame_q <= frame_q + 2'd1;
            end
          end
          default: phase_q <= PH_DONE;
        endcase
      end
    end
  end

  assign phase_o = phase_q;
  assign frame_o = frame_q;
  assign idx_o   = idx_q;

  a_r3_pre_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_PRE |-> idx_q < CNT_W'(PRE_LEN));

  a_r9_gap_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_GAP |-> idx_q < CNT_W'(IFG_LEN));

  a_r10_done_after_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_q == PH_DONE |-> frame_q == FR_PAD);

  a_r5_frame_step_at_pre: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(frame_q) |-> (phase_q == PH_PRE && idx_q == '0));

endmodule

// File: rtl/eth_tfs_bytegen.sv
module eth_tfs_bytegen
  import eth_tfs_pkg::*;
#(
  parameter int          CNT_W    = 7,
  parameter logic [47:0] DST_MAC  = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC  = 48'h02_00_00_00_00_02,
  parameter logic [15:0] TYPE_VAL = 16'h0800,
  parameter int          PAD_DATA = 10,
  parameter int          ERR_POS  = 23
) (
  input  phase_e           phase_i,
  input  logic [1:0]       frame_i,
  input  logic [CNT_W-1:0] idx_i,
  output gmii_sym_t        sym_o
);

  logic [15:0] lt_word;
  logic [7:0]  hdr_byte;
  logic [7:0]  pay_byte;
  logic [7:0]  idx8;

  assign idx8 = 8'(idx_i);

  always_comb begin
    unique case (frame_i)
      FR_TYPE: lt_word = TYPE_VAL;
      FR_PAD:  lt_word = 16'(PAD_DATA);
      default: lt_word = 16'(MIN_PAY);
    endcase
  end

  always_comb begin
    hdr_byte = 8'h00;
    for (int b = 0; b < 6; b++) begin
      if (int'(idx_i) == b)     hdr_byte = DST_MAC[8*(5-b) +: 8];
      if (int'(idx_i) == b + 6) hdr_byte = SRC_MAC[8*(5-b) +: 8];
    end
    if (int'(idx_i) == 12) hdr_byte = lt_word[15:8];
    if (int'(idx_i) == 13) hdr_byte = lt_word[7:0];
  end

  // zero fill beyond the announced length of the padded frame
  always_comb begin
    if (frame_i == FR_PAD && int'(idx_i) >= PAD_DATA) pay_byte = 8'h00;
    else                                             pay_byte = idx8 + {frame_i, 6'b0};
  end

  always_comb begin
    sym_o = '0;
    unique case (phase_i)
      PH_PRE: sym_o = '{en: 1'b1, er: 1'b0, data: PRE_BYTE};
      PH_SFD: sym_o = '{en: 1'b1, er: 1'b0, data: SFD_BYTE};
      PH_HDR: sym_o = '{en: 1'b1, er: 1'b0, data: hdr_byte};
      PH_PAY: sym_o = '{en: 1'b1,
                        er: (frame_i == FR_ERR) && (int'(idx_i) == ERR_POS),
                        data: pay_byte};
      default: sym_o = '0;
    endcase
  end

endmodule

// File: rtl/eth_tfs_outreg.sv
module eth_tfs_outreg
  import eth_tfs_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      ce_i,
  input  logic      fin_i,
  input  gmii_sym_t sym_i,
  output gmii_sym_t sym_o,
  output logic      done_o
);

  gmii_sym_t sym_q;
  logic      done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sym_q  <= '0;
      done_q <= 1'b0;
    end else if (ce_i) begin
      if (fin_i) begin
        sym_q  <= '0;
        done_q <= 1'b1;
      end else begin
        sym_q  <= sym_i;
      end
    end
  end

  assign sym_o  = sym_q;
  assign done_o = done_q;

  a_r11_er_needs_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_q.er |-> sym_q.en);

  a_r7_single_er_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sym_q.er && ce_i |=> !sym_q.er);

endmodule

// File: rtl/eth_tfs_top.sv
module eth_tfs_top
  import eth_tfs_pkg::*;
#(
  parameter int          IFG_LEN      = 12,
  parameter int          TYPE_PAY_LEN = 64,
  parameter logic [47:0] DST_MAC      = 48'h02_00_00_00_00_01,
  parameter logic [47:0] SRC_MAC      = 48'h02_00_00_00_00_02,
  parameter logic [15:0] TYPE_VAL     = 16'h0800,
  parameter int          PAD_DATA     = 10,
  parameter int          ERR_POS      = 23
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ce_i,
  output logic [7:0] txd_o,
  output logic       tx_en_o,
  output logic       tx_er_o,
  output logic       done_o
);

  localparam int MAX_A   = (TYPE_PAY_LEN > MIN_PAY) ? TYPE_PAY_LEN : MIN_PAY;
  localparam int MAX_B   = (IFG_LEN > HDR_LEN) ? IFG_LEN : HDR_LEN;
  localparam int MAX_LEN = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  phase_e           phase;
  logic [1:0]       frame;
  logic [CNT_W-1:0] idx;
  gmii_sym_t        sym_next;
  gmii_sym_t        sym_out;

  eth_tfs_ctrl #(
    .CNT_W       (CNT_W),
    .IFG_LEN     (IFG_LEN),
    .TYPE_PAY_LEN(TYPE_PAY_LEN)
  ) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ce_i   (ce_i),
    .phase_o(phase),
    .frame_o(frame),
    .idx_o  (idx)
  );

  eth_tfs_bytegen #(
    .CNT_W   (CNT_W),
    .DST_MAC (DST_MAC),
    .SRC_MAC (SRC_MAC),
    .TYPE_VAL(TYPE_VAL),
    .PAD_DATA(PAD_DATA),
    .ERR_POS (ERR_POS)
  ) u_gen (
    .phase_i(phase),
    .frame_i(frame),
    .idx_i  (idx),
    .sym_o  (sym_next)
  );

  eth_tfs_outreg u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ce_i  (ce_i),
    .fin_i (phase == PH_DONE),
    .sym_i (sym_next),
    .sym_o (sym_out),
    .done_o(done_o)
  );

  assign txd_o   = sym_out.data;
  assign tx_en_o = sym_out.en;
  assign tx_er_o = sym_out.er;

  a_r2_hold_without_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ce_i |=> $stable(txd_o) && $stable(tx_en_o) && $stable(tx_er_o) && $stable(done_o));

  a_r10_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> done_o);

  a_r10_idle_when_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !tx_en_o && !tx_er_o && txd_o == 8'h00);

  a_r9_gap_data_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_o |-> txd_o == 8'h00);

endmodule

// File: tb/tb_eth_tfs_top.sv
module tb_eth_tfs_top;

  localparam int          CLK_PERIOD = 10;
  localparam logic [47:0] DA         = 48'h02_00_00_00_00_01;
  localparam logic [47:0] SA         = 48'h02_00_00_00_00_02;
  localparam int          GAP        = 12;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ce_i = 1'b0;
  logic [7:0] txd_o;
  logic       tx_en_o, tx_er_o, done_o;

  int n_vec = 0;
  int n_bad = 0;
  int pos   = 0;
  int n_sym = 0;
  int er_seen = 0;
  int er_stray = 0;
  logic [10:0] last_obs;

  always #(CLK_PERIOD/2) clk = ~clk;

  eth_tfs_top dut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_i(ce_i),
    .txd_o(txd_o), .tx_en_o(tx_en_o), .tx_er_o(tx_er_o), .done_o(done_o)
  );

  function automatic int pay_of(int f);
    return (f == 1) ? 64 : 46;
  endfunction

  function automatic int total_syms();
    int t = 0;
    for (int f = 0; f < 4; f++) t += 8 + 14 + pay_of(f) + GAP;
    return t;
  endfunction

  // expected {done,en,er,data} at byte position p
  function automatic logic [10:0] exp_sym(input int p, output string tag);
    int q = p;
    logic [15:0] lt;
    int h, k, dlen;
    for (int f = 0; f < 4; f++) begin
      int flen = 8 + 14 + pay_of(f);
      if (q < flen) begin
        if (q < 7) begin tag = "R3"; return {1'b0, 1'b1, 1'b0, 8'h55}; end
        if (q == 7) begin tag = "R3"; return {1'b0, 1'b1, 1'b0, 8'hD5}; end
        h = q - 8;
        lt = (f == 1) ? 16'h0800 : (f == 3) ? 16'd10 : 16'd46;
        if (h < 6)  begin tag = "R4"; return {3'b010, DA[47-8*h -: 8]}; end
        if (h < 12) begin tag = "R4"; return {3'b010, SA[47-8*(h-6) -: 8]}; end
        if (h == 12) begin tag = "R4"; return {3'b010, lt[15:8]}; end
        if (h == 13) begin tag = "R4"; return {3'b010, lt[7:0]}; end
        k = h - 14;
        dlen = (f == 3) ? 10 : pay_of(f);
        case (f)
          0: tag = "R5";
          1: tag = "R6";
          2: tag = "R7";
          default: tag = "R8";
        endcase
        return {1'b0, 1'b1, (f == 2 && k == 23),
                (k < dlen) ? 8'((k + 64*f) % 256) : 8'h00};
      end
      q -= flen;
      if (q < GAP) begin tag = "R9"; return 11'h0; end
      q -= GAP;
    end
    tag = "R10";
    return {1'b1, 10'h0};
  endfunction

  task automatic check(input string tag, input logic [10:0] exp);
    logic [10:0] act = {done_o, tx_en_o, tx_er_o, txd_o};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s pos=%0d act=%03h exp=%03h", tag, pos, act, exp);
    end
  endtask

  // apply ce for one edge, sample at the following negedge
  task automatic cyc(input bit ce);
    string tag;
    logic [10:0] e;
    ce_i = ce;
    @(negedge clk);
    if (tx_er_o && !tx_en_o) er_stray++;
    if (ce) begin
      e = exp_sym(pos, tag);
      if (tx_er_o) er_seen++;
      check(tag, e);
      pos++;
    end else begin
      check("R2", last_obs); // R2: no change without ce
    end
    last_obs = {done_o, tx_en_o, tx_er_o, txd_o};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    ce_i = 1'b1;
    #1;
    check("R1", 11'h0); // R1: idle in reset
    @(negedge clk);
    check("R1", 11'h0);
    rst_ni = 1'b1;
    ce_i = 1'b0;
    @(negedge clk);
    check("R1", 11'h0);
    last_obs = 11'h0;
    pos = 0;
    er_seen = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0017);
    n_sym = total_syms();

    // pass 1: random ce, ~2/3 duty
    do_reset();
    while (pos <= n_sym + 4) cyc(($urandom % 3) != 0);
    n_vec++;
    if (er_seen != 1) begin n_bad++; $display("FAIL R7 er_count act=%0d exp=1", er_seen); end
    repeat (30) cyc(($urandom % 2) != 0); // R10: stays done

    // pass 2: reset mid-frame, then full rate with a long hold
    do_reset();
    while (pos < 40) cyc(1'b1);
    do_reset();
    while (pos < 120) cyc(1'b1);
    repeat (25) cyc(1'b0); // R2: long stall mid-frame
    while (pos <= n_sym + 2) cyc(1'b1);
    n_vec++;
    if (er_seen != 1) begin n_bad++; $display("FAIL R7 er_count act=%0d exp=1", er_seen); end

    // pass 3: slow-channel enable, one edge in ten
    do_reset();
    while (pos <= n_sym + 1) begin
      cyc(1'b1);
      repeat (9) cyc(1'b0);
    end

    // pass 4: sparse random ce
    do_reset();
    while (pos <= n_sym + 1) cyc(($urandom % 5) == 0);

    n_vec++;
    if (er_stray != 0) begin n_bad++; $display("FAIL R11 stray_er act=%0d exp=0", er_stray); end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule